// File: doc/BRIEF.md
# Clear-On-Read Interrupt Source Controller

This block gathers the interrupt causes of one serial channel together with two device-wide causes (a timer expiry and a general I/O level change). Every cause raises a pending flag on a one-cycle event pulse. The flag stays set until the bus performs a specific read, and that read clears it as a side effect. Different causes are tied to different reads. No software write is ever needed to clear a flag.

A per-source enable vector masks flags from the interrupt line without altering them. The pending vector is always visible, and the lowest-numbered enabled pending source is reported as a 4-bit code. The receive-ready cause is level aware. A receive data read clears it only when the FIFO will then be below its trigger level.

Source bit map, which is also the priority order (lowest bit wins): 0 line status, 1 receive ready, 2 receive time-out, 3 transmit ready, 4 modem status, 5 flow-control delta (RTS/CTS or DTR/DSR), 6 Xon/Xoff or special character, 7 wake-up, 8 timer expiry, 9 I/O level.

Top module: `cor_int_ctrl`

## Requirements
- R1: After reset, pend_o is all zero, irq_o is low and src_id_o is 10, the code meaning no source.
- R2: An event pulse on evt_i[k] sets pend_o[k] from the next clock edge, and the flag holds until its own clearing read.
- R3: A pulse on rd_lsr_i clears pend_o[0] (line status) and no other flag.
- R4: A pulse on rd_msr_i clears pend_o[4] (modem status) and pend_o[5] (flow-control delta) and no other flag.
- R5: A pulse on rd_isr_i clears pend_o[3] (transmit ready) and pend_o[6] (Xon/Xoff or special character) and no other flag.
- R6: A pulse on rd_rxdata_i always clears pend_o[2] (receive time-out). It clears pend_o[1] (receive ready) only when rx_level_i, the occupancy before the read, is not greater than rx_trig_i. Otherwise pend_o[1] stays set.
- R7: A pulse on rd_gint_i clears pend_o[7] (wake-up) and no other flag.
- R8: A pulse on rd_tmrctl_i clears pend_o[8] (timer), and a pulse on rd_iolvl_i clears pend_o[9] (I/O level). Neither touches any other flag.
- R9: When an event and its clearing read arrive in the same cycle, the flag is set after the edge.
- R10: irq_o is high exactly when some bit of pend_o & en_i is set. en_i never changes pend_o.
- R11: src_id_o is the index of the lowest set bit of pend_o & en_i, or 10 when there is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | One-cycle event pulse per source |
| en_i | input | 10 | Per-source interrupt enable |
| rd_lsr_i | input | 1 | Line status register read strobe |
| rd_msr_i | input | 1 | Modem status register read strobe |
| rd_isr_i | input | 1 | Interrupt status register read strobe |
| rd_gint_i | input | 1 | Global interrupt register read strobe |
| rd_rxdata_i | input | 1 | Receive FIFO data read strobe |
| rd_tmrctl_i | input | 1 | Timer control register read strobe |
| rd_iolvl_i | input | 1 | I/O level register read strobe |
| rx_level_i | input | 7 | Receive FIFO occupancy before the current read |
| rx_trig_i | input | 7 | Receive trigger level |
| pend_o | output | 10 | Pending flags |
| src_id_o | output | 4 | Highest-priority enabled pending source, 10 if none |
| irq_o | output | 1 | Combined interrupt line |

## Verification
A source event and the read that clears it can land in the same cycle. The bench provokes this in two ways. Directed steps pulse every event together with every read strobe. Random traffic also makes the two collide often, because it drives events and strobes at high density. After each edge, the bench compares every flag with a model in which set takes precedence over clear. It also drives receive data reads with the occupancy just above the trigger and exactly at it, so both outcomes for receive ready are judged.

// File: rtl/cor_int_pkg.sv
package cor_int_pkg;
  localparam int N_SRC = 10;
  localparam int SRC_W = $clog2(N_SRC + 1);

  typedef enum int {
    SRC_LINE  = 0,
    SRC_RXRDY = 1,
    SRC_RXTO  = 2,
    SRC_TXRDY = 3,
    SRC_MODEM = 4,
    SRC_FLOW  = 5,
    SRC_XCHR  = 6,
    SRC_WAKE  = 7,
    SRC_TIMER = 8,
    SRC_IOLVL = 9
  } src_e;

  typedef struct packed {
    logic lsr;
    logic msr;
    logic isr;
    logic gint;
    logic rxdata;
    logic tmrctl;
    logic iolvl;
  } rd_strb_t;
endpackage

// File: rtl/cor_pend_bit.sv
module cor_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has precedence so a colliding event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R9
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o); // R2
endmodule

// File: rtl/cor_clr_map.sv
module cor_clr_map
  import cor_int_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  rd_strb_t         rd_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  output logic [N_SRC-1:0] clr_o
);
  logic rx_above;
  assign rx_above = rx_level_i > rx_trig_i;

  always_comb begin
    clr_o            = '0;
    clr_o[SRC_LINE]  = rd_i.lsr;
    clr_o[SRC_RXRDY] = rd_i.rxdata & ~rx_above;
    clr_o[SRC_RXTO]  = rd_i.rxdata;
    clr_o[SRC_TXRDY] = rd_i.isr;
    clr_o[SRC_MODEM] = rd_i.msr;
    clr_o[SRC_FLOW]  = rd_i.msr;
    clr_o[SRC_XCHR]  = rd_i.isr;
    clr_o[SRC_WAKE]  = rd_i.gint;
    clr_o[SRC_TIMER] = rd_i.tmrctl;
    clr_o[SRC_IOLVL] = rd_i.iolvl;
  end
endmodule

// File: rtl/cor_prio_enc.sv
module cor_prio_enc
  import cor_int_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic [SRC_W-1:0] id_o
);
  always_comb begin
    id_o = SRC_W'(N_SRC);
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = SRC_W'(i);
    end
  end

  AST_ID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (id_o < SRC_W'(N_SRC) && req_i[id_o])); // R11
  AST_ID_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |-> (id_o == SRC_W'(N_SRC))); // R11
  AST_ID_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> ((req_i & ((N_SRC'(1) << id_o) - N_SRC'(1))) == '0)); // R11
endmodule

// File: rtl/cor_int_ctrl.sv
module cor_int_ctrl
  import cor_int_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             rd_lsr_i,
  input  logic             rd_msr_i,
  input  logic             rd_isr_i,
  input  logic             rd_gint_i,
  input  logic             rd_rxdata_i,
  input  logic             rd_tmrctl_i,
  input  logic             rd_iolvl_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [SRC_W-1:0] src_id_o,
  output logic             irq_o
);
  rd_strb_t         rd;
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] act;

  assign rd = '{lsr: rd_lsr_i, msr: rd_msr_i, isr: rd_isr_i, gint: rd_gint_i,
                rxdata: rd_rxdata_i, tmrctl: rd_tmrctl_i, iolvl: rd_iolvl_i};

  cor_clr_map #(.LVL_W(LVL_W)) u_clr_map (
    .rd_i       (rd),
    .rx_level_i (rx_level_i),
    .rx_trig_i  (rx_trig_i),
    .clr_o      (clr)
  );

  for (genvar k = 0; k < N_SRC; k++) begin : g_pend
    cor_pend_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i[k]),
      .clr_i  (clr[k]),
      .q_o    (pend_o[k])
    );
  end

  assign act   = pend_o & en_i;
  assign irq_o = |act;

  cor_prio_enc u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (act),
    .id_o   (src_id_o)
  );

  AST_RXRDY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rxdata_i && (rx_level_i > rx_trig_i) && pend_o[SRC_RXRDY]) |=> pend_o[SRC_RXRDY]); // R6
  AST_RXTO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rxdata_i && !evt_i[SRC_RXTO]) |=> !pend_o[SRC_RXTO]); // R6
  AST_MSR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_msr_i && !evt_i[SRC_MODEM] && !evt_i[SRC_FLOW]) |=> !(pend_o[SRC_MODEM] | pend_o[SRC_FLOW])); // R4
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (src_id_o != SRC_W'(N_SRC))); // R10
endmodule

// File: tb/cor_int_ctrl_bench.sv
module cor_int_ctrl_bench;
  import cor_int_pkg::*;
  localparam int LVL_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_SRC-1:0] evt = '0, en = '0;
  logic lsr = 0, msr = 0, isr = 0, gint = 0, rxd = 0, tmr = 0, iol = 0;
  logic [LVL_W-1:0] lvl = '0, trig = '0;
  logic [N_SRC-1:0] pend;
  logic [SRC_W-1:0] sid;
  logic irq;

  int checks = 0, fails = 0;
  logic [N_SRC-1:0] exp_pend = '0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  cor_int_ctrl #(.LVL_W(LVL_W)) u_cor_int_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .en_i(en),
    .rd_lsr_i(lsr), .rd_msr_i(msr), .rd_isr_i(isr), .rd_gint_i(gint),
    .rd_rxdata_i(rxd), .rd_tmrctl_i(tmr), .rd_iolvl_i(iol),
    .rx_level_i(lvl), .rx_trig_i(trig),
    .pend_o(pend), .src_id_o(sid), .irq_o(irq)
  );

  function automatic logic [N_SRC-1:0] model_next(logic [N_SRC-1:0] p);
    logic [N_SRC-1:0] c = '0;
    c[0] = lsr;
    c[1] = rxd && !(lvl > trig);
    c[2] = rxd;
    c[3] = isr; c[6] = isr;
    c[4] = msr; c[5] = msr;
    c[7] = gint; c[8] = tmr; c[9] = iol;
    return evt | (p & ~c);
  endfunction

  function automatic int model_id(logic [N_SRC-1:0] m);
    for (int i = 0; i < N_SRC; i++) if (m[i]) return i;
    return N_SRC;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    chk({req, " pend"}, int'(pend), int'(exp_pend));
    chk("R10 irq", int'(irq), int'(|(exp_pend & en)));
    chk("R11 src_id", int'(sid), model_id(exp_pend & en));
  endtask

  task automatic idle();
    evt = '0; lsr = 0; msr = 0; isr = 0; gint = 0; rxd = 0; tmr = 0; iol = 0;
  endtask

  // inputs are set at the falling edge; outputs checked at the next falling edge
  task automatic step(string req);
    exp_pend = model_next(exp_pend);
    @(negedge clk);
    check_outs(req);
    idle();
  endtask

  task automatic fill_all();
    idle(); evt = '1; step("R2");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    en = '1;
    repeat (2) @(negedge clk);
    chk("R1 pend", int'(pend), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 src_id", int'(sid), N_SRC);
    rst_n = 1'b1;
    @(negedge clk);

    fill_all();
    lsr = 1; step("R3");
    msr = 1; step("R4");
    isr = 1; step("R5");
    lvl = 7'd5; trig = 7'd4; rxd = 1; step("R6 above trigger keeps rxrdy");
    lvl = 7'd4; trig = 7'd4; rxd = 1; step("R6 at trigger clears rxrdy");
    gint = 1; step("R7");
    tmr = 1; step("R8 timer");
    iol = 1; step("R8 iolvl");
    chk("R2 all cleared", int'(pend), 0);

    // set and clear collide
    evt = '1; lsr = 1; msr = 1; isr = 1; gint = 1; rxd = 1; tmr = 1; iol = 1;
    lvl = '0; trig = '0;
    step("R9");

    en = '0; step("R10 masked");
    en = 10'b10_0000_0000; step("R11 only top");
    en = 10'b10_0001_0000; step("R11 two enabled");

    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < N_SRC; k++) evt[k] = ($urandom % 6) == 0;
      lsr  = ($urandom % 5) == 0;
      msr  = ($urandom % 5) == 0;
      isr  = ($urandom % 5) == 0;
      gint = ($urandom % 5) == 0;
      rxd  = ($urandom % 4) == 0;
      tmr  = ($urandom % 5) == 0;
      iol  = ($urandom % 5) == 0;
      lvl  = LVL_W'($urandom % 8);
      trig = LVL_W'($urandom % 8);
      if (($urandom % 8) == 0) en = N_SRC'($urandom);
      step("R2 random");
    end

    done = 1'b1;
    finish_run();
  end
endmodule